// File: doc/BRIEF.md
# Indexed Address Generator with Page-Cross Cycles

This unit resolves the effective address of an 8-bit processor operand for the indexed and indirect addressing modes. It fetches operand and pointer bytes through a byte-wide read port and inserts the dummy bus cycles that the processor issues. Those dummy cycles cover index fix-up in zero page, page-boundary carry in absolute and post-indexed modes, forced fix-up cycles for write-type opcodes, and the extra cycle of the indirect jumps. A variant input selects the older or the newer silicon behaviour for the dummy read addresses and for the indirect-jump page wrap.

A caller presents the mode, both index registers, the variant, the force bit and the address of the first operand byte, then pulses `start`. The generator drives one bus cycle per clock and then pulses `ea_valid` together with the final address and the advanced program counter. The data access itself belongs to the caller.

Top module: `agen_top`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, `busy`, `mem_rd`, `mem_dummy` and `ea_valid` are all low.
- R2: Modes 0 (zero page + X) and 1 (zero page + Y) read one operand byte at `pc_start`, then make one dummy read: at `{8'h00, operand}` when `newer`=0, or at `pc_start+1` when `newer`=1. The result is `{8'h00, (operand + index) mod 256}`. The force bit has no effect.
- R3: Mode 2 (pre-indexed indirect, X) makes the same dummy read as R2, then reads the pointer low byte at `(operand+X) mod 256` and the high byte at `(operand+X+1) mod 256`, both in page zero.
- R4: Mode 3 (post-indexed indirect, Y) reads the pointer at `{00, operand}` and `{00, (operand+1) mod 256}`, with no preceding dummy cycle, and returns pointer + Y with a full 16-bit carry.
- R5: In modes 3, 4 (absolute + X) and 5 (absolute + Y), when base + index changes the high byte, one dummy read follows the last fetch. It is at `{base[15:8], sum[7:0]}` when `newer`=0, or at the current program counter (the address after the last operand byte) when `newer`=1.
- R6: In modes 3, 4 and 5 without a page change, `force_extra`=1 adds one dummy read at the final address, and `force_extra`=0 adds no cycle.
- R7: Two-byte operands (modes 4 to 7) are read low byte first at `pc_start` and `pc_start+1`. `pc_next` equals `pc_start` plus the operand length (1 for modes 0 to 3, 2 for modes 4 to 7).
- R8: Mode 6 (indirect jump) with `newer`=0 reads the target low byte at the pointer and the high byte at `{ptr[15:8], (ptr[7:0]+1) mod 256}`. With `newer`=1 it first makes a dummy read at `pc_start+2`, then reads the target at ptr and ptr+1 with a full carry.
- R9: Mode 7 (indexed indirect jump) makes one dummy read at `pc_start+2`, then reads the target at ptr+X and ptr+X+1, each with a full 16-bit carry.
- R10: `ea_valid` is a one-cycle pulse in the cycle after the last bus cycle, with no read in that cycle. `busy` is high from the cycle after an accepted `start` through the `ea_valid` cycle. A `start` while `busy` is ignored.
- R11: `mem_dummy` is high exactly on dummy reads and only together with `mem_rd`. `newer`=1 selects the newer variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address calculation (sampled when idle) |
| mode | input | 3 | Addressing mode code (see R2 to R9) |
| newer | input | 1 | 1 selects newer-variant behaviour |
| force_extra | input | 1 | Opcode always takes the fix-up cycle |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc_start | input | 16 | Address of the first operand byte |
| mem_addr | output | 16 | Read address for the current bus cycle |
| mem_rd | output | 1 | A bus read happens this cycle |
| mem_dummy | output | 1 | The current read's data is discarded |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| busy | output | 1 | Operation in progress |
| ea | output | 16 | Effective address, valid with ea_valid |
| ea_valid | output | 1 | One-cycle result strobe |
| pc_next | output | 16 | Program counter past the operand bytes |

## Verification
A wrong sequencer state shows on the bus within one clock, as an extra, missing or misplaced read, because every state drives its own address. A wrong index, carry or wrap corrupts either the very next pointer read address or the `ea` value at the strobe. The bench therefore logs every bus cycle of each operation and compares address and dummy flag cycle by cycle. A mishandled page-cross decision changes the cycle count, so the strobe arrives one cycle early or late.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int AW = 16;
    localparam int BW = 8;
    localparam int PW = AW - BW;

    typedef logic [AW-1:0] addr_t;
    typedef logic [BW-1:0] byte_t;

    typedef enum logic [2:0] {
        AM_ZPX  = 3'd0,
        AM_ZPY  = 3'd1,
        AM_IZX  = 3'd2,
        AM_IZY  = 3'd3,
        AM_ABX  = 3'd4,
        AM_ABY  = 3'd5,
        AM_JIND = 3'd6,
        AM_JIDX = 3'd7
    } amode_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPLO, ST_OPHI, ST_PRE, ST_PLO, ST_PHI, ST_FIX, ST_DONE
    } step_t;

    typedef struct packed {
        amode_t mode;
        logic   newer;
        logic   frc;
        byte_t  idx;
        addr_t  pc;
        addr_t  opnd;
        byte_t  tlo;
        addr_t  base;
        addr_t  ea;
    } ctx_t;

    function automatic logic zp_indexed(amode_t m);
        return (m == AM_ZPX) || (m == AM_ZPY);
    endfunction

    function automatic logic long_operand(amode_t m);
        return m[2];
    endfunction

    function automatic byte_t pick_index(amode_t m, byte_t x, byte_t y);
        case (m)
            AM_ZPY, AM_IZY, AM_ABY: return y;
            AM_JIND:                return '0;
            default:                return x;
        endcase
    endfunction

    function automatic addr_t in_page0(byte_t b);
        return {{PW{1'b0}}, b};
    endfunction

    function automatic logic page_changed(addr_t b, addr_t s);
        return b[AW-1:BW] != s[AW-1:BW];
    endfunction
endpackage

// File: rtl/agen_seq.sv
module agen_seq
    import agen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  amode_t mode_i,
    input  logic   newer_i,
    input  logic   frc_i,
    input  byte_t  x_i,
    input  byte_t  y_i,
    input  addr_t  pc_i,
    input  byte_t  rdata,
    output step_t  st,
    output ctx_t   ctx
);
    step_t st_n;
    ctx_t  ctx_n;
    addr_t abs_base, ind_base, abs_sum, ind_sum;

    always_comb begin
        abs_base = {rdata, ctx.opnd[BW-1:0]};
        ind_base = {rdata, ctx.tlo};
        abs_sum  = abs_base + in_page0(ctx.idx);
        ind_sum  = ind_base + in_page0(ctx.idx);
    end

    always_comb begin
        st_n  = st;
        ctx_n = ctx;
        case (st)
            ST_IDLE: if (start) begin
                ctx_n.mode  = mode_i;
                ctx_n.newer = newer_i;
                ctx_n.frc   = frc_i;
                ctx_n.idx   = pick_index(mode_i, x_i, y_i);
                ctx_n.pc    = pc_i;
                st_n        = ST_OPLO;
            end
            ST_OPLO: begin
                ctx_n.opnd[BW-1:0] = rdata;
                ctx_n.pc           = ctx.pc + 1'b1;
                if (long_operand(ctx.mode))  st_n = ST_OPHI;
                else if (ctx.mode == AM_IZY) st_n = ST_PLO;
                else                         st_n = ST_PRE;
            end
            ST_OPHI: begin
                ctx_n.opnd[AW-1:BW] = rdata;
                ctx_n.pc            = ctx.pc + 1'b1;
                if (ctx.mode == AM_ABX || ctx.mode == AM_ABY) begin
                    ctx_n.base = abs_base;
                    ctx_n.ea   = abs_sum;
                    st_n = (page_changed(abs_base, abs_sum) || ctx.frc) ? ST_FIX : ST_DONE;
                end else if (ctx.mode == AM_JIND && !ctx.newer) begin
                    st_n = ST_PLO;
                end else begin
                    st_n = ST_PRE;
                end
            end
            ST_PRE: begin
                if (zp_indexed(ctx.mode)) begin
                    ctx_n.ea = in_page0(ctx.opnd[BW-1:0] + ctx.idx);
                    st_n     = ST_DONE;
                end else begin
                    st_n = ST_PLO;
                end
            end
            ST_PLO: begin
                ctx_n.tlo = rdata;
                st_n      = ST_PHI;
            end
            ST_PHI: begin
                if (ctx.mode == AM_IZY) begin
                    ctx_n.base = ind_base;
                    ctx_n.ea   = ind_sum;
                    st_n = (page_changed(ind_base, ind_sum) || ctx.frc) ? ST_FIX : ST_DONE;
                end else begin
                    ctx_n.ea = ind_base;
                    st_n     = ST_DONE;
                end
            end
            ST_FIX:  st_n = ST_DONE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ctx <= '0;
        end else begin
            st  <= st_n;
            ctx <= ctx_n;
        end
    end
endmodule

// File: rtl/agen_busmux.sv
module agen_busmux
    import agen_pkg::*;
(
    input  step_t st,
    input  ctx_t  ctx,
    output addr_t mem_addr,
    output logic  mem_rd,
    output logic  mem_dummy
);
    byte_t zlo, zix, zix1, zlo1;
    addr_t full_ix;

    always_comb begin
        zlo     = ctx.opnd[BW-1:0];
        zlo1    = zlo + 1'b1;
        zix     = zlo + ctx.idx;
        zix1    = zix + 1'b1;
        full_ix = ctx.opnd + in_page0(ctx.idx);

        mem_addr  = ctx.pc;
        mem_rd    = 1'b0;
        mem_dummy = 1'b0;
        case (st)
            ST_OPLO, ST_OPHI: mem_rd = 1'b1;
            ST_PRE: begin
                mem_rd    = 1'b1;
                mem_dummy = 1'b1;
                if ((zp_indexed(ctx.mode) || ctx.mode == AM_IZX) && !ctx.newer)
                    mem_addr = in_page0(zlo);
            end
            ST_PLO: begin
                mem_rd = 1'b1;
                case (ctx.mode)
                    AM_IZX:  mem_addr = in_page0(zix);
                    AM_IZY:  mem_addr = in_page0(zlo);
                    default: mem_addr = full_ix;
                endcase
            end
            ST_PHI: begin
                mem_rd = 1'b1;
                case (ctx.mode)
                    AM_IZX:  mem_addr = in_page0(zix1);
                    AM_IZY:  mem_addr = in_page0(zlo1);
                    AM_JIND: mem_addr = ctx.newer ? ctx.opnd + 1'b1
                                                  : {ctx.opnd[AW-1:BW], zlo1};
                    default: mem_addr = full_ix + 1'b1;
                endcase
            end
            ST_FIX: begin
                mem_rd    = 1'b1;
                mem_dummy = 1'b1;
                if (!page_changed(ctx.base, ctx.ea)) mem_addr = ctx.ea;
                else if (!ctx.newer) mem_addr = {ctx.base[AW-1:BW], ctx.ea[BW-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  mode,
    input  logic        newer,
    input  logic        force_extra,
    input  logic [7:0]  idx_x,
    input  logic [7:0]  idx_y,
    input  logic [15:0] pc_start,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_dummy,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic [15:0] ea,
    output logic        ea_valid,
    output logic [15:0] pc_next
);
    step_t st;
    ctx_t  ctx;

    agen_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_i  (amode_t'(mode)),
        .newer_i (newer),
        .frc_i   (force_extra),
        .x_i     (idx_x),
        .y_i     (idx_y),
        .pc_i    (pc_start),
        .rdata   (mem_rdata),
        .st      (st),
        .ctx     (ctx)
    );

    agen_busmux u_bus (
        .st        (st),
        .ctx       (ctx),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_dummy (mem_dummy)
    );

    assign busy     = (st != ST_IDLE);
    assign ea_valid = (st == ST_DONE);
    assign ea       = ctx.ea;
    assign pc_next  = ctx.pc;
endmodule

// File: rtl/agen_chk.sv
module agen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  mode,
    input logic        busy,
    input logic        mem_rd,
    input logic        mem_dummy,
    input logic        ea_valid,
    input logic [15:0] ea
);
    logic [2:0] seen_mode;
    logic [3:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_mode <= '0;
            rd_cnt    <= '0;
        end else if (start && !busy) begin
            seen_mode <= mode;
            rd_cnt    <= '0;
        end else if (mem_rd && rd_cnt != 4'hF) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !ea_valid));

    p_zp_page_r2: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && seen_mode[2:1] == 2'b00) |-> (ea[15:8] == 8'h00));

    p_read_count_r7: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (rd_cnt >= 4'd2 && rd_cnt <= 4'd5));

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    p_no_read_at_valid_r10: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> !mem_rd);

    p_start_taken_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_dummy_is_read_r11: assert property (@(posedge clk) disable iff (rst)
        mem_dummy |-> mem_rd);
endmodule

bind agen_top agen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_dummy (mem_dummy),
    .ea_valid  (ea_valid),
    .ea        (ea)
);

// File: tb/sim_agen_top.sv
module sim_agen_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic        newer = 1'b0;
    logic        force_extra = 1'b0;
    logic [7:0]  idx_x = '0;
    logic [7:0]  idx_y = '0;
    logic [15:0] pc_start = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_dummy, busy, ea_valid;
    logic [7:0]  mem_rdata;
    logic [15:0] ea, pc_next;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    agen_top u0 (.*);

    // Memory image: byte at address a is a[7:0] + a[15:8] + 1.
    function automatic logic [7:0] memv(logic [15:0] a);
        return a[7:0] + a[15:8] + 8'd1;
    endfunction
    assign mem_rdata = memv(mem_addr);

    typedef struct packed {
        logic [2:0]  mode;
        logic        newer;
        logic        frc;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [15:0] pc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 8'h10, 8'h00, 16'h0200, 4'd2},
        '{3'd0, 1'b1, 1'b0, 8'hF0, 8'h00, 16'h0230, 4'd2},
        '{3'd1, 1'b0, 1'b0, 8'h00, 8'hC0, 16'h12F0, 4'd2},
        '{3'd1, 1'b1, 1'b1, 8'h00, 8'h07, 16'h0044, 4'd2},
        '{3'd2, 1'b0, 1'b0, 8'h05, 8'h00, 16'h30FA, 4'd3},
        '{3'd2, 1'b1, 1'b0, 8'hEA, 8'h00, 16'h0410, 4'd3},
        '{3'd3, 1'b0, 1'b1, 8'h00, 8'h20, 16'h01FD, 4'd4},
        '{3'd3, 1'b0, 1'b0, 8'h00, 8'h20, 16'h01FD, 4'd4},
        '{3'd3, 1'b1, 1'b0, 8'h00, 8'hC0, 16'h0050, 4'd5},
        '{3'd3, 1'b0, 1'b0, 8'h00, 8'hC0, 16'h0050, 4'd5},
        '{3'd4, 1'b0, 1'b0, 8'hFF, 8'h00, 16'h0300, 4'd5},
        '{3'd4, 1'b1, 1'b0, 8'hFF, 8'h00, 16'h0300, 4'd5},
        '{3'd5, 1'b0, 1'b0, 8'h00, 8'h10, 16'h0300, 4'd6},
        '{3'd5, 1'b1, 1'b1, 8'h00, 8'h10, 16'h0300, 4'd6},
        '{3'd6, 1'b0, 1'b0, 8'h00, 8'h00, 16'h20DE, 4'd8},
        '{3'd6, 1'b1, 1'b0, 8'h00, 8'h00, 16'h20DE, 4'd8},
        '{3'd7, 1'b1, 1'b0, 8'h01, 8'h00, 16'h20DE, 4'd9}
    };

    function automatic string rtag(int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected bus trace, computed from the requirements.
    logic [15:0] xa [8];
    bit          xd [8];
    int          xn;
    logic [15:0] xea, xpc;

    task automatic put(logic [15:0] a, bit d);
        if (xn < 8) begin xa[xn] = a; xd[xn] = d; end
        xn++;
    endtask

    task automatic model(vec_t v);
        logic [15:0] p, base, ptr, t, ha;
        logic [7:0]  b0, b1, lo, hi, ix, z;
        xn = 0;
        p  = v.pc;
        ix = (v.mode == 3'd1 || v.mode == 3'd3 || v.mode == 3'd5) ? v.y :
             (v.mode == 3'd6) ? 8'h00 : v.x;
        b0 = memv(p); put(p, 0); p = p + 1;
        case (v.mode)
            3'd0, 3'd1: begin
                put(v.newer ? p : {8'h00, b0}, 1);
                xea = {8'h00, 8'(b0 + ix)};
            end
            3'd2: begin
                put(v.newer ? p : {8'h00, b0}, 1);
                z = b0 + ix;
                lo = memv({8'h00, z}); put({8'h00, z}, 0);
                z = z + 1;
                hi = memv({8'h00, z}); put({8'h00, z}, 0);
                xea = {hi, lo};
            end
            3'd3: begin
                lo = memv({8'h00, b0}); put({8'h00, b0}, 0);
                z = b0 + 1;
                hi = memv({8'h00, z}); put({8'h00, z}, 0);
                base = {hi, lo};
                xea = base + {8'h00, ix};
                if (base[15:8] != xea[15:8]) put(v.newer ? p : {base[15:8], xea[7:0]}, 1);
                else if (v.frc) put(xea, 1);
            end
            3'd4, 3'd5: begin
                b1 = memv(p); put(p, 0); p = p + 1;
                base = {b1, b0};
                xea = base + {8'h00, ix};
                if (base[15:8] != xea[15:8]) put(v.newer ? p : {base[15:8], xea[7:0]}, 1);
                else if (v.frc) put(xea, 1);
            end
            3'd6: begin
                b1 = memv(p); put(p, 0); p = p + 1;
                ptr = {b1, b0};
                if (v.newer) put(p, 1);
                lo = memv(ptr); put(ptr, 0);
                ha = v.newer ? ptr + 1 : {b1, 8'(b0 + 1)};
                hi = memv(ha); put(ha, 0);
                xea = {hi, lo};
            end
            default: begin
                b1 = memv(p); put(p, 0); p = p + 1;
                put(p, 1);
                t = {b1, b0} + {8'h00, v.x};
                lo = memv(t); put(t, 0);
                hi = memv(t + 1); put(t + 1, 0);
                xea = {hi, lo};
            end
        endcase
        xpc = p;
    endtask

    task automatic run(vec_t v, bit glitch);
        logic [15:0] ga [8];
        bit          gd [8];
        int          n = 0;
        bit          got = 0;
        logic [15:0] gea = '0, gpc = '0;
        string       rq = rtag(int'(v.req));
        model(v);
        @(negedge clk);
        start = 1; mode = v.mode; newer = v.newer; force_extra = v.frc;
        idx_x = v.x; idx_y = v.y; pc_start = v.pc;
        @(negedge clk);
        start = glitch;
        if (glitch) begin mode = 3'd0; pc_start = 16'hBEEF; idx_x = 8'h33; end
        for (int k = 0; k < 12; k++) begin
            if (ea_valid) begin got = 1; gea = ea; gpc = pc_next; break; end
            if (mem_rd) begin
                if (n < 8) begin ga[n] = mem_addr; gd[n] = mem_dummy; end
                n++;
            end
            @(negedge clk);
            start = 0;
        end
        start = 0;
        chk(got, "R10", "strobe seen", 32'(got), 1);
        chk(n == xn, rq, "bus cycle count", n, xn);
        for (int i = 0; i < 8; i++) begin
            if (i < n && i < xn) begin
                chk(ga[i] == xa[i], rq, $sformatf("addr of cycle %0d", i), ga[i], xa[i]);
                chk(gd[i] == xd[i], "R11", $sformatf("dummy flag of cycle %0d", i), gd[i], xd[i]);
            end
        end
        chk(gea == xea, rq, "effective address", gea, xea);
        chk(gpc == xpc, "R7", "pc_next", gpc, xpc);
        @(negedge clk);
        chk(!ea_valid, "R10", "strobe one cycle", ea_valid, 0);
        chk(!busy, "R10", "idle after strobe", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_rd && !ea_valid && !mem_dummy, "R1", "outputs in reset",
            {busy, mem_rd, ea_valid, mem_dummy}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !mem_rd && !ea_valid, "R1", "idle after reset",
            {busy, mem_rd, ea_valid}, 0);

        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

        // R10: start while busy is ignored (absolute + X cross, older)
        run(VECS[10], 1'b1);

        // R1: reset in the middle of an operation
        @(negedge clk);
        start = 1; mode = 3'd7; newer = 1; pc_start = 16'h0400;
        @(negedge clk); start = 0;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(!busy && !mem_rd && !ea_valid && !mem_dummy, "R1", "mid-run reset",
            {busy, mem_rd, ea_valid, mem_dummy}, 0);
        @(negedge clk);
        chk(!busy && !mem_rd, "R1", "stays idle", {busy, mem_rd}, 0);

        // operation still works after the abort
        run(VECS[16], 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule